// File: doc/BRIEF.md
# Slot Table Allocation Engine

This block builds the contents of a memory arbiter's time-slot table in hardware. Each client presents a requested slot count and an active flag, and the engine also takes a budget of spare slots for clients that are active but asked for nothing. On a start pulse the engine captures this configuration. It then spreads each client's slots evenly across the table and hands spare slots to active clients that made no request. Any entries still empty are filled round-robin among the active clients. The finished table leaves the block as a stream of writes, one client number per slot index, in ascending slot order.

The engine replaces a software loop that would otherwise rewrite the table whenever bandwidth is granted or released. It also guards the table against overcommitment: a configuration whose requested slots add up to more than the table size is refused as a whole.

Top module: `slot_table_builder`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `done` and `reject` are all low.
- R2: Inputs are captured on a `start` pulse while idle. A `start` while `busy` is high is ignored: the running build keeps the configuration it captured and emits exactly NUM_SLOTS writes.
- R3: If the sum of all requested counts exceeds NUM_SLOTS, `reject` is high for one cycle, one cycle after `start`. No write follows and `busy` stays low. A sum exactly equal to NUM_SLOTS is accepted.
- R4: Clients are placed one at a time in ascending index order, starting from an all-empty table. A client with request n>0 uses interval NUM_SLOTS/n (integer division). The scan starts at position 0. An occupied position advances the scan by one. An empty position is given to the client and advances the scan by the interval. The scan stops when the position reaches NUM_SLOTS.
- R5: A client with request 0 and its active flag set is placed with interval NUM_SLOTS (its one slot is the first empty position). This happens only while the spare budget is above zero, and each such placement lowers the budget by one.
- R6: A client with request 0 and its active flag clear receives no placement.
- R7: After placement, each empty slot, in slot order, receives the first active client found at or after a round-robin pointer. The pointer starts at client 0 for every build and then moves to one past the chosen client, wrapping at NUM_CLIENTS.
- R8: If no client is active, an empty slot receives the pointer value itself, and the pointer advances by one.
- R9: Writes are issued one per cycle with consecutive `wr_slot` values from 0 to NUM_SLOTS-1. `wr_client` is always below NUM_CLIENTS.
- R10: `done` is high for exactly one cycle, in the cycle after the write for slot NUM_SLOTS-1. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a build (ignored while busy) |
| req_counts | input | NUM_CLIENTS*CNT_W | Requested slot count per client, client k at bits [k*CNT_W +: CNT_W] |
| client_active | input | NUM_CLIENTS | Active flag per client, bit k for client k |
| spare_budget | input | CNT_W | Number of spare slots for active zero-request clients |
| busy | output | 1 | A build is in progress |
| reject | output | 1 | One-cycle pulse: configuration overcommits the table |
| wr_valid | output | 1 | A table write is presented this cycle |
| wr_slot | output | IDX_W | Slot index of the write |
| wr_client | output | CL_W | Client number written to that slot |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
A wrong occupancy bit or a wrong scan position in the placement pass stays hidden until the fill pass reads the table. It then shows as a wrong `wr_client` on one or more slots of the output stream, after the whole placement pass has run. The bench therefore compares every slot of every build with an arithmetic model. A corrupted round-robin pointer shifts every later filled slot, so a single error spreads along the rest of the stream. Errors in control state show sooner: a missing `reject`, a write stream that is too short or out of order, or `done` in the wrong cycle.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SCAN,
        ST_FILL,
        ST_FIN
    } build_state_e;

    // Successor of v in a ring of lim elements.
    function automatic int ring_next(int v, int lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/slot_interval.sv
module slot_interval #(
    parameter int NUM_SLOTS = 64,
    parameter int CNT_W     = 7
) (
    input  logic [CNT_W-1:0] req,
    input  logic             active,
    input  logic [CNT_W-1:0] budget,
    output logic             take,
    output logic             use_spare,
    output logic [CNT_W-1:0] interval
);

    always_comb begin
        take      = 1'b0;
        use_spare = 1'b0;
        interval  = CNT_W'(NUM_SLOTS);
        if (req != '0) begin
            take     = 1'b1;
            interval = CNT_W'(NUM_SLOTS / int'(req));
            if (interval == '0)
                interval = CNT_W'(1);
        end else if (active && budget != '0) begin
            take      = 1'b1;
            use_spare = 1'b1;
        end
    end

endmodule

// File: rtl/slot_rr_pick.sv
module slot_rr_pick #(
    parameter int NUM_CLIENTS = 15,
    parameter int CL_W        = 4
) (
    input  logic [NUM_CLIENTS-1:0] active,
    input  logic [CL_W-1:0]        ptr,
    output logic [CL_W-1:0]        pick
);

    // Nearest active client at or after ptr; ptr itself when none is active.
    always_comb begin
        pick = ptr;
        for (int k = NUM_CLIENTS - 1; k >= 0; k--) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= NUM_CLIENTS)
                idx = idx - NUM_CLIENTS;
            if (active[idx])
                pick = CL_W'(idx);
        end
    end

endmodule

// File: rtl/slot_table_store.sv
module slot_table_store #(
    parameter int NUM_SLOTS = 64,
    parameter int CL_W      = 4,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [CL_W-1:0]  wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic             rd_used,
    output logic [CL_W-1:0]  rd_client
);

    logic [NUM_SLOTS-1:0] used;
    logic [CL_W-1:0]      owner [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (rst || clr)
            used <= '0;
        else if (we)
            used[waddr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we)
            owner[waddr] <= wdata;
    end

    assign rd_used   = used[raddr];
    assign rd_client = owner[raddr];

endmodule

// File: rtl/slot_table_builder.sv
module slot_table_builder
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 15,
    localparam int IDX_W      = $clog2(NUM_SLOTS),
    localparam int CNT_W      = IDX_W + 1,
    localparam int CL_W       = $clog2(NUM_CLIENTS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [NUM_CLIENTS*CNT_W-1:0] req_counts,
    input  logic [NUM_CLIENTS-1:0]       client_active,
    input  logic [CNT_W-1:0]             spare_budget,
    output logic                         busy,
    output logic                         reject,
    output logic                         wr_valid,
    output logic [IDX_W-1:0]             wr_slot,
    output logic [CL_W-1:0]              wr_client,
    output logic                         done
);

    localparam int SUM_W = CNT_W + $clog2(NUM_CLIENTS + 1);

    build_state_e state;

    logic [NUM_CLIENTS-1:0][CNT_W-1:0] req_q;
    logic [NUM_CLIENTS-1:0]            act_q;
    logic [CNT_W-1:0]                  budget_q;
    logic [CL_W-1:0]                   ci;
    logic [CNT_W-1:0]                  pos;
    logic [CNT_W-1:0]                  ivl_q;
    logic [IDX_W-1:0]                  fidx;
    logic [CL_W-1:0]                   rr;

    logic             wr_valid_q, done_q, reject_q;
    logic [IDX_W-1:0] wr_slot_q;
    logic [CL_W-1:0]  wr_client_q;

    // Admission: total requested slots against table size.
    logic [SUM_W-1:0] req_sum;
    logic             overcommit;
    always_comb begin
        req_sum = '0;
        for (int k = 0; k < NUM_CLIENTS; k++)
            req_sum = req_sum + SUM_W'(req_counts[k*CNT_W +: CNT_W]);
    end
    assign overcommit = req_sum > SUM_W'(NUM_SLOTS);

    logic last_ci, pos_end;
    assign last_ci = (ci == CL_W'(NUM_CLIENTS - 1));
    assign pos_end = (pos >= CNT_W'(NUM_SLOTS));

    // Per-client placement parameters.
    logic             take, use_spare;
    logic [CNT_W-1:0] interval;
    slot_interval #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_interval (
        .req       (req_q[ci]),
        .active    (act_q[ci]),
        .budget    (budget_q),
        .take      (take),
        .use_spare (use_spare),
        .interval  (interval)
    );

    // Table occupancy and owners.
    logic             tbl_clr, tbl_we, rd_used;
    logic [IDX_W-1:0] tbl_raddr;
    logic [CL_W-1:0]  rd_client;
    assign tbl_clr   = (state == ST_IDLE) && start && !overcommit;
    assign tbl_we    = (state == ST_SCAN) && !pos_end && !rd_used;
    assign tbl_raddr = (state == ST_FILL) ? fidx : pos[IDX_W-1:0];

    slot_table_store #(.NUM_SLOTS(NUM_SLOTS), .CL_W(CL_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (tbl_clr),
        .we        (tbl_we),
        .waddr     (pos[IDX_W-1:0]),
        .wdata     (ci),
        .raddr     (tbl_raddr),
        .rd_used   (rd_used),
        .rd_client (rd_client)
    );

    // Round-robin choice for empty slots.
    logic [CL_W-1:0] pick;
    slot_rr_pick #(.NUM_CLIENTS(NUM_CLIENTS), .CL_W(CL_W)) u_pick (
        .active (act_q),
        .ptr    (rr),
        .pick   (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            req_q       <= '0;
            act_q       <= '0;
            budget_q    <= '0;
            ci          <= '0;
            pos         <= '0;
            ivl_q       <= '0;
            fidx        <= '0;
            rr          <= '0;
            wr_valid_q  <= 1'b0;
            wr_slot_q   <= '0;
            wr_client_q <= '0;
            done_q      <= 1'b0;
            reject_q    <= 1'b0;
        end else begin
            wr_valid_q <= 1'b0;
            done_q     <= 1'b0;
            reject_q   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (overcommit) begin
                            reject_q <= 1'b1;
                        end else begin
                            req_q    <= req_counts;
                            act_q    <= client_active;
                            budget_q <= spare_budget;
                            ci       <= '0;
                            fidx     <= '0;
                            rr       <= '0;
                            state    <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP: begin
                    if (take) begin
                        ivl_q <= interval;
                        pos   <= '0;
                        if (use_spare)
                            budget_q <= budget_q - 1'b1;
                        state <= ST_SCAN;
                    end else if (last_ci) begin
                        state <= ST_FILL;
                    end else begin
                        ci <= ci + 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (pos_end) begin
                        if (last_ci) begin
                            state <= ST_FILL;
                        end else begin
                            ci    <= ci + 1'b1;
                            state <= ST_SETUP;
                        end
                    end else if (rd_used) begin
                        pos <= pos + 1'b1;
                    end else begin
                        pos <= pos + ivl_q;
                    end
                end
                ST_FILL: begin
                    wr_valid_q <= 1'b1;
                    wr_slot_q  <= fidx;
                    if (rd_used) begin
                        wr_client_q <= rd_client;
                    end else begin
                        wr_client_q <= pick;
                        rr          <= CL_W'(ring_next(int'(pick), NUM_CLIENTS));
                    end
                    if (fidx == IDX_W'(NUM_SLOTS - 1))
                        state <= ST_FIN;
                    else
                        fidx <= fidx + 1'b1;
                end
                ST_FIN: begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign reject    = reject_q;
    assign wr_valid  = wr_valid_q;
    assign wr_slot   = wr_slot_q;
    assign wr_client = wr_client_q;
    assign done      = done_q;

endmodule

// File: rtl/slot_table_builder_chk.sv
module slot_table_builder_chk #(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 15,
    localparam int IDX_W      = $clog2(NUM_SLOTS),
    localparam int CL_W       = $clog2(NUM_CLIENTS)
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             reject,
    input logic             wr_valid,
    input logic [IDX_W-1:0] wr_slot,
    input logic [CL_W-1:0]  wr_client,
    input logic             done
);

    // R9: consecutive writes step the slot index by one
    a_r9_slot_step: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && $past(wr_valid)) |-> (wr_slot == $past(wr_slot) + 1'b1));

    // R9: a write stream opens at slot 0
    a_r9_first_slot: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> (wr_slot == '0));

    // R9: written client numbers stay in range
    a_r9_client_range: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (int'(wr_client) < NUM_CLIENTS));

    // R10: done follows the last slot write
    a_r10_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_valid) && $past(wr_slot) == IDX_W'(NUM_SLOTS - 1) && !busy));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: a rejected configuration starts nothing
    a_r3_reject_idle: assert property (@(posedge clk) disable iff (rst)
        reject |-> (!busy && !wr_valid));

    // R2: writes only appear during a build
    a_r2_write_in_build: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);

endmodule

bind slot_table_builder slot_table_builder_chk #(
    .NUM_SLOTS   (NUM_SLOTS),
    .NUM_CLIENTS (NUM_CLIENTS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .reject    (reject),
    .wr_valid  (wr_valid),
    .wr_slot   (wr_slot),
    .wr_client (wr_client),
    .done      (done)
);

// File: tb/slot_table_builder_test.sv
`timescale 1ns/1ps
module slot_table_builder_test;

    localparam int NS    = 64;
    localparam int NC    = 15;
    localparam int IDX_W = $clog2(NS);
    localparam int CNT_W = IDX_W + 1;
    localparam int CL_W  = $clog2(NC);

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   start = 1'b0;
    logic [NC*CNT_W-1:0]    req_counts = '0;
    logic [NC-1:0]          client_active = '0;
    logic [CNT_W-1:0]       spare_budget = '0;
    logic                   busy, reject, wr_valid, done;
    logic [IDX_W-1:0]       wr_slot;
    logic [CL_W-1:0]        wr_client;

    slot_table_builder #(.NUM_SLOTS(NS), .NUM_CLIENTS(NC)) uut (
        .clk(clk), .rst(rst), .start(start), .req_counts(req_counts),
        .client_active(client_active), .spare_budget(spare_budget),
        .busy(busy), .reject(reject), .wr_valid(wr_valid),
        .wr_slot(wr_slot), .wr_client(wr_client), .done(done)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int req[NC];
    int act[NC];
    int budget;
    int exp_tab[NS];
    int got_slot[NS];
    int got_cl[NS];
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic int req_total();
        int s = 0;
        for (int k = 0; k < NC; k++) s += req[k];
        return s;
    endfunction

    // Table model built from the requirements.
    function automatic void build_model();
        int bud = budget;
        int cl = 0;
        for (int s = 0; s < NS; s++) exp_tab[s] = -1;
        for (int c = 0; c < NC; c++) begin
            int ivl;
            int pos = 0;
            if (req[c] == 0) begin
                if (act[c] == 0 || bud <= 0) continue;
                bud--;
                ivl = NS;
            end else begin
                ivl = NS / req[c];
            end
            while (pos < NS) begin
                if (exp_tab[pos] >= 0) pos++;
                else begin exp_tab[pos] = c; pos += ivl; end
            end
        end
        for (int s = 0; s < NS; s++) begin
            if (exp_tab[s] < 0) begin
                int first = cl;
                while (act[cl] == 0) begin
                    cl = (cl + 1) % NC;
                    if (cl == first) break;
                end
                exp_tab[s] = cl;
                cl = (cl + 1) % NC;
            end
        end
    endfunction

    task automatic drive_inputs();
        for (int k = 0; k < NC; k++) begin
            req_counts[k*CNT_W +: CNT_W] = CNT_W'(req[k]);
            client_active[k] = (act[k] != 0);
        end
        spare_budget = CNT_W'(budget);
    endtask

    task automatic clear_cfg();
        for (int k = 0; k < NC; k++) begin req[k] = 0; act[k] = 0; end
        budget = 0;
    endtask

    task automatic run_case(input string name, input bit busy_start);
        int cyc = 0;
        int nwr = 0;
        int last_wr = -1;
        int done_c = -1;
        bit busy_at_done = 1'b0;
        bit expect_rej = (req_total() > NS);
        build_model();
        drive_inputs();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (expect_rej) begin
            // R3: reject one cycle after start, then nothing
            check(reject == 1'b1, {"R3 reject pulse ", name}, int'(reject), 1);
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (wr_valid || busy || reject) nwr++;
            end
            check(nwr == 0, {"R3 no activity after reject ", name}, nwr, 0);
            return;
        end
        check(reject == 1'b0, {"R3 accepted sum ", name}, int'(reject), 0);
        while (done_c < 0 && cyc < 4000) begin
            if (wr_valid) begin
                if (nwr < NS) begin
                    got_slot[nwr] = int'(wr_slot);
                    got_cl[nwr]   = int'(wr_client);
                end
                nwr++;
                last_wr = cyc;
            end
            if (done) begin
                done_c = cyc;
                busy_at_done = busy;
            end
            if (done_c < 0) begin
                @(negedge clk);
                cyc++;
                if (busy_start && cyc == 5) begin
                    // R2: a second start while busy, with other inputs
                    req_counts    = '0;
                    client_active = '1;
                    spare_budget  = CNT_W'(NS);
                    start = 1'b1;
                end
                if (busy_start && cyc == 6) start = 1'b0;
            end
        end
        check(nwr == NS, {"R2/R9 write count ", name}, nwr, NS);
        if (nwr == NS) begin
            for (int s = 0; s < NS; s++) begin
                check(got_slot[s] == s, {"R9 slot order ", name}, got_slot[s], s);
                check(got_cl[s] == exp_tab[s], {"R4/R5/R6/R7/R8 slot client ", name},
                      got_cl[s], exp_tab[s]);
            end
        end
        // R10: done one cycle after the last write, busy low
        check(done_c == last_wr + 1, {"R10 done timing ", name}, done_c, last_wr + 1);
        check(busy_at_done == 1'b0, {"R10 busy at done ", name}, int'(busy_at_done), 0);
        @(negedge clk);
        check(done == 1'b0, {"R10 done single pulse ", name}, int'(done), 0);
    endtask

    function automatic int rnd(input int lim);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr) % lim;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs in reset and right after it
        check(!busy && !wr_valid && !done && !reject, "R1 reset state",
              int'({busy, wr_valid, done, reject}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !wr_valid && !done && !reject, "R1 after reset",
              int'({busy, wr_valid, done, reject}), 0);

        // R8: nobody active, nothing requested
        clear_cfg();
        run_case("no active", 1'b0);

        // R4: one client owns the whole table
        clear_cfg();
        req[0] = 64; act[0] = 1;
        run_case("full single", 1'b0);

        // R4/R7: sweep one client's request across the full range
        for (int n = 1; n <= NS; n++) begin
            clear_cfg();
            req[3] = n; act[3] = 1; act[9] = 1;
            run_case($sformatf("sweep n=%0d", n), 1'b0);
        end

        // R5/R6: spare handout limited by the budget, inactive ignored
        clear_cfg();
        req[0] = 3; act[0] = 1;
        req[1] = 4; act[1] = 1;
        act[2] = 1; act[5] = 1; act[7] = 1; act[9] = 1;
        budget = 2;
        run_case("spare budget 2", 1'b0);

        // R5: budget large enough for every active zero-request client
        clear_cfg();
        for (int k = 0; k < NC; k++) act[k] = (k % 2);
        req[14] = 5; act[14] = 1;
        budget = 30;
        run_case("spare budget large", 1'b0);

        // R3: one over the table size, then exactly the table size
        clear_cfg();
        req[0] = 40; req[1] = 25; act[0] = 1; act[1] = 1;
        run_case("sum 65", 1'b0);
        clear_cfg();
        req[0] = 40; req[1] = 24; act[0] = 1; act[1] = 1;
        run_case("sum 64", 1'b0);

        // R2: start during a build has no effect
        clear_cfg();
        req[2] = 7; req[6] = 9; act[2] = 1; act[6] = 1; act[11] = 1;
        budget = 1;
        run_case("start while busy", 1'b1);

        // Mixed pseudo-random configurations (some overcommit)
        for (int t = 0; t < 40; t++) begin
            clear_cfg();
            for (int k = 0; k < NC; k++) begin
                act[k] = rnd(2);
                req[k] = (rnd(3) == 0) ? rnd(9) : 0;
            end
            budget = rnd(6);
            run_case($sformatf("mixed %0d", t), 1'b0);
        end

        finish_run();
    end

endmodule